// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The block collects a large number of level-sensitive interrupt sources and reduces them to one request line per group of eight sources. Each group's request goes to a parent interrupt controller, which sees only the group line. Software then finds out which sources in the group are active by reading a status word. Sources are numbered flat: source `s` belongs to group `s/8` and sits at bit `s%8` within that group.

Four groups share one 32-bit register bank, so each group occupies one byte lane. Each bank has an enable word. Software changes it only through two write ports: one that sets bits and one that clears bits. Software can read the enable word back, for example to save and later restore it. A status word shows the enabled, active sources, and software services the lowest set bit of its group's byte first. The number of groups is a parameter, with a default of 20 groups (160 sources, 5 banks).

Top module: `irq_group_combiner`

## Requirements
- R1: Group g takes sources `src_i[8g+7:8g]` and drives `irq_o[g]`. Its enables and status occupy bits `[8(g%4)+7 : 8(g%4)]` of bank `g/4`.
- R2: Bank k is decoded at byte address `k*16`. Address bits [3:2] select the word within the bank. Address bits [1:0] are ignored.
- R3: A write to word 0 of a bank (offset 0x0) sets every enable bit whose write-data bit is 1 and leaves every other enable bit unchanged.
- R4: A write to word 1 of a bank (offset 0x4) clears every enable bit whose write-data bit is 1 and leaves every other enable bit unchanged.
- R5: A read of offset 0x0 returns the bank's 32 enable bits in the same cycle.
- R6: A read of offset 0xC returns, in the same cycle, bit i set exactly when source i of that bank is high and its enable bit is set.
- R7: `irq_o[g]` is a register. At each clock edge it loads the OR of group g's eight enabled, active sources, so it follows a source or enable change one clock later.
- R8: While `rst_ni` is low, all enable bits are cleared and every `irq_o` bit is low.
- R9: Reads of offsets 0x4 and 0x8, and reads of any address whose bank index is at or beyond the bank count, return zero. Writes to offsets 0x8 and 0xC, and writes beyond the last bank, change no enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 8*NUM_GROUPS | Level-sensitive interrupt sources |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i`, combinational |
| irq_o | output | NUM_GROUPS | Registered request line per group |

## Verification
The bench aims writes at every word of every bank and at banks past the last one. A design that decoded the word offset wrongly, or aliased the unmapped banks onto real ones, would show enable bits changing where the model holds them still. Overlapping set and clear patterns expose a design that overwrites the whole word instead of acting only on 1 bits. The bench compares group lines every clock while sources toggle freely. A request line that is combinational, or that lags by two clocks, fails in the cycle after an enable or source edge. A single source in an upper byte lane checks that group and lane indices line up, and a write with nonzero low address bits checks that those bits are ignored.

// File: rtl/comb_pkg.sv
`timescale 1ns/1ps
package comb_pkg;
  localparam int LANE_W  = 8;
  localparam int LANES   = 4;
  localparam int BANK_W  = LANE_W * LANES;
  localparam int STRIDE_LSB = 4;

  typedef enum logic [1:0] {
    WOFF_SET  = 2'd0,
    WOFF_CLR  = 2'd1,
    WOFF_RSV  = 2'd2,
    WOFF_STAT = 2'd3
  } word_off_e;
endpackage

// File: rtl/comb_decode.sv
`timescale 1ns/1ps
module comb_decode
  import comb_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 8,
  localparam int BIDX_W   = ADDR_W - STRIDE_LSB
) (
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] set_o,
  output logic [NUM_BANKS-1:0] clr_o,
  output logic [BIDX_W-1:0]    bank_o,
  output word_off_e            off_o,
  output logic                 hit_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  assign bank_o = addr_i[ADDR_W-1:STRIDE_LSB];
  assign off_o  = word_off_e'(addr_i[3:2]);
  assign hit_o  = (32'(bank_o) < 32'(NUM_BANKS));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    logic this_bank;
    assign this_bank = we_i && (bank_o == BIDX_W'(b));
    assign set_o[b]  = this_bank && (off_o == WOFF_SET);
    assign clr_o[b]  = this_bank && (off_o == WOFF_CLR);
  end
endmodule

// File: rtl/comb_bank.sv
`timescale 1ns/1ps
module comb_bank
  import comb_pkg::*;
#(
  parameter int GROUPS  = 4,
  localparam int SRC_W  = GROUPS * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [SRC_W-1:0]  src_i,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] stat_o,
  output logic [GROUPS-1:0] irq_o
);
  logic [SRC_W-1:0] en_q;
  logic [SRC_W-1:0] wbits;
  logic [SRC_W-1:0] stat;

  assign wbits = wdata_i[SRC_W-1:0];
  assign stat  = src_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (set_i) en_q <= en_q | wbits;
    else if (clr_i) en_q <= en_q & ~wbits;
  end

  if (SRC_W < BANK_W) begin : g_pad
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[BANK_W-1:SRC_W];
    assign en_o   = {{(BANK_W-SRC_W){1'b0}}, en_q};
    assign stat_o = {{(BANK_W-SRC_W){1'b0}}, stat};
  end else begin : g_full
    assign en_o   = en_q;
    assign stat_o = stat;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic irq_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |stat[g*LANE_W +: LANE_W];
    end
    assign irq_o[g] = irq_q;

    // R7
    irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] == $past(|(src_i[g*LANE_W +: LANE_W] & en_q[g*LANE_W +: LANE_W])));
  end

  // R3
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((en_q & $past(wbits)) == $past(wbits)));

  // R4
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((en_q & $past(wbits)) == '0));

  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(en_q));
endmodule

// File: rtl/irq_group_combiner.sv
`timescale 1ns/1ps
module irq_group_combiner
  import comb_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [8*NUM_GROUPS-1:0] src_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic [NUM_GROUPS-1:0]   irq_o
);
  localparam int NUM_BANKS = (NUM_GROUPS + LANES - 1) / LANES;
  localparam int BIDX_W    = ADDR_W - STRIDE_LSB;

  logic [NUM_BANKS-1:0] set_w, clr_w;
  logic [BIDX_W-1:0]    bank_w;
  word_off_e            off_w;
  logic                 hit_w;
  logic [BANK_W-1:0]    en_w   [NUM_BANKS];
  logic [BANK_W-1:0]    stat_w [NUM_BANKS];

  comb_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .we_i   (we_i),
    .addr_i (addr_i),
    .set_o  (set_w),
    .clr_o  (clr_w),
    .bank_o (bank_w),
    .off_o  (off_w),
    .hit_o  (hit_w)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int GB = (NUM_GROUPS - LANES*b >= LANES) ? LANES : NUM_GROUPS - LANES*b;
    comb_bank #(.GROUPS(GB)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_w[b]),
      .clr_i   (clr_w[b]),
      .wdata_i (wdata_i),
      .src_i   (src_i[b*BANK_W +: GB*LANE_W]),
      .en_o    (en_w[b]),
      .stat_o  (stat_w[b]),
      .irq_o   (irq_o[b*LANES +: GB])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit_w && bank_w == BIDX_W'(b)) begin
        if (off_w == WOFF_SET)       rdata_o = en_w[b];
        else if (off_w == WOFF_STAT) rdata_o = stat_w[b];
      end
    end
  end

  // R9
  rd_unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_w || off_w == WOFF_CLR || off_w == WOFF_RSV) |-> (rdata_o == '0));
endmodule

// File: tb/irq_group_combiner_bench.sv
`timescale 1ns/1ps
module irq_group_combiner_bench;
  localparam int NG = 20;
  localparam int NS = NG * 8;
  localparam int NB = (NG + 3) / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NG-1:0] irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  run = 1'b0;
  bit  done = 1'b0;

  bit            en_m [NS];
  logic [NG-1:0] exp_irq;

  always #5 clk = ~clk;

  irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(8)) u_irq_group_combiner (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int b, off;
    logic [31:0] r;
    b = int'(a) >> 4;
    off = (int'(a) >> 2) & 3;
    r = '0;
    if (b < NB) begin
      for (int j = 0; j < 32; j++) begin
        if (b*32 + j < NS) begin
          if (off == 0)      r[j] = en_m[b*32+j];
          else if (off == 3) r[j] = en_m[b*32+j] & src[b*32+j];
        end
      end
    end
    return r;
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) en_m[i] = 1'b0;
      exp_irq = '0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        exp_irq[g] = 1'b0;
        for (int i = 0; i < 8; i++) exp_irq[g] = exp_irq[g] | (en_m[g*8+i] & src[g*8+i]);
      end
      if (we && (int'(addr) >> 4) < NB) begin
        for (int j = 0; j < 32; j++) begin
          int idx;
          idx = (int'(addr) >> 4) * 32 + j;
          if (idx < NS && wdata[j]) begin
            if (((addr >> 2) & 8'd3) == 8'd0)      en_m[idx] = 1'b1;
            else if (((addr >> 2) & 8'd3) == 8'd1) en_m[idx] = 1'b0;
          end
        end
      end
    end
  end

  // per-clock comparison
  always @(posedge clk) begin
    #2;
    if (run && rst_n) begin
      chk("R7 irq", 64'(irq), 64'(exp_irq));
      if ((int'(addr) >> 4) >= NB)              chk("R9 rd", 64'(rdata), 64'(exp_rd(addr)));
      else if (((addr >> 2) & 8'd3) == 8'd0)    chk("R5 rd", 64'(rdata), 64'(exp_rd(addr)));
      else if (((addr >> 2) & 8'd3) == 8'd3)    chk("R6 rd", 64'(rdata), 64'(exp_rd(addr)));
      else                                      chk("R9 rd", 64'(rdata), 64'(exp_rd(addr)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] e);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #2;
    chk(tag, 64'(rdata), 64'(e));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    src = '1;
    addr = 8'h00;
    #23;
    // R8: reset state
    chk("R8 irq in reset", 64'(irq), 64'd0);
    chk("R8 enable in reset", 64'(rdata), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); src = '0; run = 1'b1;

    // R3: set in bank 1
    wr(8'h10, 32'h0000_00FF);
    rd_chk("R3 set", 8'h10, 32'h0000_00FF);
    wr(8'h10, 32'h0F00_0000);
    rd_chk("R3 set keeps others", 8'h10, 32'h0F00_00FF);
    // R4: clear
    wr(8'h14, 32'h0100_000F);
    rd_chk("R4 clear", 8'h10, 32'h0E00_00F0);
    // R2: low address bits ignored
    wr(8'h13, 32'h0000_2000);
    rd_chk("R2 low bits ignored", 8'h11, 32'h0E00_20F0);
    // R1: source 45 -> group 5, bank 1 bit 13
    @(negedge clk); src = '0; src[45] = 1'b1;
    @(posedge clk); #2;
    chk("R1 group line", 64'(irq), 64'(1) << 5);
    rd_chk("R1 status lane", 8'h1C, 32'h0000_2000);
    // R9: writes to 0x8 / 0xC and beyond last bank
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'hF4, 32'hFFFF_FFFF);
    rd_chk("R9 ignored writes", 8'h10, 32'h0E00_20F0);
    rd_chk("R9 bank0 untouched", 8'h00, 32'h0);
    rd_chk("R9 read 0x4", 8'h14, 32'h0);
    rd_chk("R9 read 0x8", 8'h18, 32'h0);
    rd_chk("R9 read beyond", 8'h50, 32'h0);
    // R6: status with mixed sources in last bank
    wr(8'h40, 32'hA5A5_A5A5);
    @(negedge clk); src = '1;
    rd_chk("R6 status", 8'h4C, 32'hA5A5_A5A5);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      for (int i = 0; i < NS; i++) src[i] = ($urandom % 4) == 0;
      we = ($urandom % 3) == 0;
      addr = 8'(((($urandom % 8) << 4) | (($urandom % 4) << 2) | ($urandom % 4)));
      wdata = $urandom & $urandom;
    end
    @(negedge clk); we = 1'b0;
    @(negedge clk);
    run = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule